// File: doc/BRIEF.md
# Board Control Register File

This block is the register front end of a board-management FPGA. A host reaches it over a plain 32-bit bus made of an address, write strobe, read strobe, write data and read data. Through this bus the host sets an 8-bit LED bar and an 8-bit general-purpose output byte. It also fills an eight-character ASCII display buffer, requests a system reset, and bit-bangs a two-wire serial EEPROM port. That port has a clock line, a data line, an output-enable pair and a select bit.

The display buffer can be loaded in two ways. One register takes a whole 32-bit word and writes its eight-digit uppercase hexadecimal text across all eight characters. Eight single-character registers each overwrite one position. An offset window is set aside for a UART that sits next to this block on the same bus, and this block leaves that window alone. Reads of any other unmapped offset return zero and raise a one-cycle error flag.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset the LED byte, GPO byte, I2C output-enable, I2C output, I2C select, reset request and read data are all zero, and every display character holds 0x20.
- R2: Only address bits 19..0 select a register; any value in bits 31..20 reaches the same register.
- R3: A write to offset 0x008 stores write data bits 7..0 on led_o. A read of that offset returns the byte zero-extended.
- R4: A write to offset 0x410 sets character i (0 to 7) to the ASCII code of write data nibble bits [31-4i : 28-4i]. Values 0-9 map to 0x30-0x39 and values 10-15 map to 0x41-0x46. Character i appears on disp_o[8i+7:8i].
- R5: A write to offset 0x418 + 8*i stores write data bits 7..0 into character i and leaves the other characters unchanged. A read of that offset returns the character.
- R6: A read of offset 0x000 returns 0x00000000.
- R7: A write to offset 0x500 drives rst_req_o high for exactly the one cycle after the write.
- R8: Offset 0xA00 holds an 8-bit GPO byte, 0xB00 a 2-bit output-enable and 0xB18 a 1-bit select. Each keeps the low bits of the write data and reads back zero-extended.
- R9: A write to offset 0xB10 drives bit 1 onto scl_o and bit 0 onto sda_o. A read of that offset returns those two bits.
- R10: A read of offset 0xB08 returns bit 1 of the last value written to 0xB10 in bit 1, and the sda_i level at the read in bit 0, with zeros above. Writes to 0xB08 have no effect.
- R11: For offsets 0x900-0x9FF, writes change no output and reads return zero without raising bus_bad_o.
- R12: A read of any other unmapped offset returns zero and sets bus_bad_o for exactly one cycle. Writes to such offsets change no output.
- R13: Read data and bus_bad_o are registered and appear in the cycle after the read strobe. bus_rdata_o is zero in every cycle that does not follow a read. Write effects appear in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 32 | Byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_bad_o | output | 1 | One-cycle flag for a read of an unmapped offset |
| led_o | output | 8 | LED bar |
| disp_o | output | 64 | Eight display characters, character i at bits 8i+7..8i |
| gpo_o | output | 8 | General-purpose output byte |
| i2c_oe_o | output | 2 | I2C output-enable bits |
| i2c_sel_o | output | 1 | I2C select bit |
| scl_o | output | 1 | I2C clock drive |
| sda_o | output | 1 | I2C data drive |
| sda_i | input | 1 | I2C data level returned by the EEPROM |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Every result arrives one clock after its strobe. A write lands on the outputs at the first rising edge after it is presented, and read data and the error flag sit in their registers for exactly the next cycle. The bench drives the strobes on falling edges and samples outputs at the following falling edge, so each result is read in its own cycle. One more falling edge then confirms that the reset pulse, the error flag and the read data have gone back to zero. The sweeps cover all 256 LED values, hexadecimal words that put every nibble value in every position, every character slot and every combination of I2C output and returned data level.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

    localparam int unsigned OFF_W = 20;

    localparam logic [OFF_W-1:0] OFF_SWITCH  = 20'h00000;
    localparam logic [OFF_W-1:0] OFF_LED     = 20'h00008;
    localparam logic [OFF_W-1:0] OFF_HEXWORD = 20'h00410;
    localparam logic [OFF_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [OFF_W-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [OFF_W-1:0] OFF_UART_LO = 20'h00900;
    localparam logic [OFF_W-1:0] OFF_UART_HI = 20'h009FF;
    localparam logic [OFF_W-1:0] OFF_GPO     = 20'h00A00;
    localparam logic [OFF_W-1:0] OFF_I2C_OE  = 20'h00B00;
    localparam logic [OFF_W-1:0] OFF_I2C_IN  = 20'h00B08;
    localparam logic [OFF_W-1:0] OFF_I2C_OUT = 20'h00B10;
    localparam logic [OFF_W-1:0] OFF_I2C_SEL = 20'h00B18;

    // log2 of the byte stride between single-character registers
    localparam int unsigned CHAR_STRIDE_SH = 3;

    localparam logic [7:0] ASCII_SPACE = 8'h20;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_UART,
        SEL_SWITCH,
        SEL_LED,
        SEL_HEXWORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_GPO,
        SEL_I2C_OE,
        SEL_I2C_IN,
        SEL_I2C_OUT,
        SEL_I2C_SEL
    } reg_sel_e;

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
    import board_ctl_pkg::*;
#(
    parameter int unsigned DEC_W  = OFF_W,
    parameter int unsigned NCHARS = 8,
    localparam int unsigned IDX_W = (NCHARS > 1) ? $clog2(NCHARS) : 1
) (
    input  logic [DEC_W-1:0] off_i,
    output reg_sel_e         sel_o,
    output logic [IDX_W-1:0] char_idx_o
);

    localparam logic [DEC_W-1:0] CHAR_LO = DEC_W'(OFF_CHAR0);
    localparam logic [DEC_W-1:0] CHAR_HI =
        DEC_W'(OFF_CHAR0) + DEC_W'((NCHARS - 1) << CHAR_STRIDE_SH);

    logic in_char_range;

    always_comb begin
        in_char_range = (off_i >= CHAR_LO) && (off_i <= CHAR_HI) &&
                        (off_i[CHAR_STRIDE_SH-1:0] == '0);
        char_idx_o    = '0;
        sel_o         = SEL_NONE;

        if ((off_i >= DEC_W'(OFF_UART_LO)) && (off_i <= DEC_W'(OFF_UART_HI))) begin
            sel_o = SEL_UART;
        end else if (in_char_range) begin
            sel_o      = SEL_CHAR;
            char_idx_o = IDX_W'((off_i - CHAR_LO) >> CHAR_STRIDE_SH);
        end else begin
            unique case (off_i)
                DEC_W'(OFF_SWITCH):  sel_o = SEL_SWITCH;
                DEC_W'(OFF_LED):     sel_o = SEL_LED;
                DEC_W'(OFF_HEXWORD): sel_o = SEL_HEXWORD;
                DEC_W'(OFF_SOFTRST): sel_o = SEL_SOFTRST;
                DEC_W'(OFF_GPO):     sel_o = SEL_GPO;
                DEC_W'(OFF_I2C_OE):  sel_o = SEL_I2C_OE;
                DEC_W'(OFF_I2C_IN):  sel_o = SEL_I2C_IN;
                DEC_W'(OFF_I2C_OUT): sel_o = SEL_I2C_OUT;
                DEC_W'(OFF_I2C_SEL): sel_o = SEL_I2C_SEL;
                default:             sel_o = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/board_ctl_hex2asc.sv
module board_ctl_hex2asc (
    input  logic [3:0] nib_i,
    output logic [7:0] asc_o
);

    always_comb begin
        if (nib_i < 4'd10) begin
            asc_o = 8'h30 + {4'b0000, nib_i};
        end else begin
            asc_o = 8'h37 + {4'b0000, nib_i};
        end
    end

endmodule

// File: rtl/board_ctl_disp.sv
module board_ctl_disp
    import board_ctl_pkg::*;
#(
    parameter int unsigned NCHARS = 8,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned IDX_W = (NCHARS > 1) ? $clog2(NCHARS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hex_we_i,
    input  logic [WORD_W-1:0]     word_i,
    input  logic                  chr_we_i,
    input  logic [IDX_W-1:0]      chr_idx_i,
    input  logic [7:0]            chr_i,
    output logic [NCHARS*8-1:0]   chars_o
);

    typedef logic [NCHARS-1:0][7:0] char_buf_t;

    char_buf_t asc_w;
    char_buf_t buf_d;
    char_buf_t buf_q;

    // character 0 takes the most significant nibble
    for (genvar gi = 0; gi < NCHARS; gi++) begin : gen_hex
        board_ctl_hex2asc i_hex2asc (
            .nib_i (word_i[WORD_W-1-4*gi -: 4]),
            .asc_o (asc_w[gi])
        );
    end

    always_comb begin
        buf_d = buf_q;
        if (hex_we_i) begin
            buf_d = asc_w;
        end
        if (chr_we_i && (32'(chr_idx_i) < NCHARS)) begin
            buf_d[chr_idx_i] = chr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= {NCHARS{ASCII_SPACE}};
        end else begin
            buf_q <= buf_d;
        end
    end

    assign chars_o = buf_q;

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hex_we_i || chr_we_i) |-> $stable(chars_o)); // R5

    AST_HEX_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hex_we_i) |-> (((chars_o[7:0] >= 8'h30) && (chars_o[7:0] <= 8'h39)) ||
                             ((chars_o[7:0] >= 8'h41) && (chars_o[7:0] <= 8'h46)))); // R4

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEC_W  = OFF_W,
    parameter int unsigned NCHARS = 8,
    parameter int unsigned LED_W  = 8,
    parameter int unsigned GPO_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                bus_bad_o,
    output logic [LED_W-1:0]    led_o,
    output logic [NCHARS*8-1:0] disp_o,
    output logic [GPO_W-1:0]    gpo_o,
    output logic [1:0]          i2c_oe_o,
    output logic                i2c_sel_o,
    output logic                scl_o,
    output logic                sda_o,
    input  logic                sda_i,
    output logic                rst_req_o
);

    localparam int unsigned IDX_W  = (NCHARS > 1) ? $clog2(NCHARS) : 1;
    localparam int unsigned I2C_W  = 2;
    localparam int unsigned SCL_B  = 1;
    localparam int unsigned SDA_B  = 0;

    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [GPO_W-1:0]  gpo;
        logic [I2C_W-1:0]  oe;
        logic [I2C_W-1:0]  i2c_out;
        logic [I2C_W-1:0]  i2c_in;
        logic              sel;
        logic              rst_req;
        logic [DATA_W-1:0] rdata;
        logic              bad;
    } state_t;

    state_t st_d;
    state_t st_q;

    reg_sel_e         sel_w;
    logic [IDX_W-1:0] char_idx_w;
    logic             hex_we_w;
    logic             chr_we_w;
    logic [7:0]       char_rd_w;
    logic             unused_addr_hi;

    assign unused_addr_hi = ^bus_addr_i[ADDR_W-1:DEC_W];

    board_ctl_decode #(
        .DEC_W  (DEC_W),
        .NCHARS (NCHARS)
    ) i_decode (
        .off_i      (bus_addr_i[DEC_W-1:0]),
        .sel_o      (sel_w),
        .char_idx_o (char_idx_w)
    );

    assign hex_we_w = bus_wr_i && (sel_w == SEL_HEXWORD);
    assign chr_we_w = bus_wr_i && (sel_w == SEL_CHAR);

    board_ctl_disp #(
        .NCHARS (NCHARS),
        .WORD_W (DATA_W)
    ) i_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hex_we_i  (hex_we_w),
        .word_i    (bus_wdata_i),
        .chr_we_i  (chr_we_w),
        .chr_idx_i (char_idx_w),
        .chr_i     (bus_wdata_i[7:0]),
        .chars_o   (disp_o)
    );

    always_comb begin
        char_rd_w = '0;
        for (int i = 0; i < NCHARS; i++) begin
            if (char_idx_w == IDX_W'(i)) begin
                char_rd_w = disp_o[8*i +: 8];
            end
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        st_d.bad     = 1'b0;
        st_d.rdata   = '0;

        if (bus_wr_i) begin
            unique case (sel_w)
                SEL_LED:     st_d.led = bus_wdata_i[LED_W-1:0];
                SEL_SOFTRST: st_d.rst_req = 1'b1;
                SEL_GPO:     st_d.gpo = bus_wdata_i[GPO_W-1:0];
                SEL_I2C_OE:  st_d.oe = bus_wdata_i[I2C_W-1:0];
                SEL_I2C_OUT: begin
                    st_d.i2c_out = bus_wdata_i[I2C_W-1:0];
                    st_d.i2c_in  = bus_wdata_i[I2C_W-1:0];
                end
                SEL_I2C_SEL: st_d.sel = bus_wdata_i[0];
                default: ;
            endcase
        end

        if (bus_rd_i) begin
            unique case (sel_w)
                SEL_LED:     st_d.rdata = DATA_W'(st_q.led);
                SEL_CHAR:    st_d.rdata = DATA_W'(char_rd_w);
                SEL_GPO:     st_d.rdata = DATA_W'(st_q.gpo);
                SEL_I2C_OE:  st_d.rdata = DATA_W'(st_q.oe);
                SEL_I2C_IN:  st_d.rdata = DATA_W'({st_q.i2c_in[SCL_B], sda_i});
                SEL_I2C_OUT: st_d.rdata = DATA_W'(st_q.i2c_out);
                SEL_I2C_SEL: st_d.rdata = DATA_W'(st_q.sel);
                SEL_NONE:    st_d.bad   = 1'b1;
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign bus_bad_o   = st_q.bad;
    assign led_o       = st_q.led;
    assign gpo_o       = st_q.gpo;
    assign i2c_oe_o    = st_q.oe;
    assign i2c_sel_o   = st_q.sel;
    assign scl_o       = st_q.i2c_out[SCL_B];
    assign sda_o       = st_q.i2c_out[SDA_B];
    assign rst_req_o   = st_q.rst_req;

    AST_RST_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(bus_wr_i)); // R7

    AST_BAD_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bad_o |-> $past(bus_rd_i)); // R12

    AST_BAD_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bad_o |-> (bus_rdata_o == '0)); // R12

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd_i) |-> (bus_rdata_o == '0)); // R13

    AST_I2C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr_i) |-> $stable({scl_o, sda_o, i2c_oe_o, i2c_sel_o})); // R9

    AST_LED_GPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr_i) |-> ($stable(led_o) && $stable(gpo_o))); // R3

endmodule

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_bad;
    logic [7:0]  led;
    logic [63:0] disp;
    logic [7:0]  gpo;
    logic [1:0]  i2c_oe;
    logic        i2c_sel;
    logic        scl;
    logic        sda;
    logic        sda_in;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    board_ctl_regs i_board_ctl_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .bus_bad_o   (bus_bad),
        .led_o       (led),
        .disp_o      (disp),
        .gpo_o       (gpo),
        .i2c_oe_o    (i2c_oe),
        .i2c_sel_o   (i2c_sel),
        .scl_o       (scl),
        .sda_o       (sda),
        .sda_i       (sda_in),
        .rst_req_o   (rst_req)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the capture
    task automatic do_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rd(input logic [31:0] a, output logic [31:0] d, output logic bad);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
        bad      = bus_bad;
    endtask

    function automatic logic [7:0] hex_asc(input logic [3:0] n);
        return (n < 4'd10) ? (8'd48 + 8'(n)) : (8'd55 + 8'(n));
    endfunction

    function automatic logic [63:0] word_text(input logic [31:0] w);
        logic [63:0] t;
        for (int i = 0; i < 8; i++) t[8*i +: 8] = hex_asc(w[31-4*i -: 4]);
        return t;
    endfunction

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        bad;
        logic [31:0] w;
        logic [63:0] snap_disp;
        logic [7:0]  snap_led;
        logic [7:0]  snap_gpo;
        logic [5:0]  snap_io;

        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; sda_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(led == 8'h00, "R1 led", 64'(led), 64'h0);
        chk(gpo == 8'h00, "R1 gpo", 64'(gpo), 64'h0);
        chk({i2c_oe, i2c_sel, scl, sda, rst_req} == 6'b0, "R1 i2c/rst",
            64'({i2c_oe, i2c_sel, scl, sda, rst_req}), 64'h0);
        chk(disp == {8{8'h20}}, "R1 disp", disp, {8{8'h20}});
        chk(bus_rdata == 32'h0, "R1 rdata", 64'(bus_rdata), 64'h0);

        // R6 switch register
        do_rd(32'h0000_0000, rd, bad);
        chk(rd == 32'h0 && !bad, "R6 switch", 64'({bad, rd}), 64'h0);

        // R3 LED sweep and R13 one-cycle read data
        for (int v = 0; v < 256; v++) begin
            do_wr(32'h0000_0008, {24'hA5A5A5, 8'(v)});
            chk(led == 8'(v), "R3 led_o", 64'(led), 64'(v));
            do_rd(32'h0000_0008, rd, bad);
            chk(rd == 32'(v), "R3 led readback", 64'(rd), 64'(v));
            @(negedge clk);
            chk(bus_rdata == 32'h0, "R13 rdata idle", 64'(bus_rdata), 64'h0);
        end

        // R2 upper address bits ignored
        do_wr(32'hABC0_0008, 32'h0000_005A);
        chk(led == 8'h5A, "R2 alias write", 64'(led), 64'h5A);
        do_rd(32'h1230_0008, rd, bad);
        chk(rd == 32'h5A, "R2 alias read", 64'(rd), 64'h5A);
        do_wr(32'hFFF0_0418, 32'h0000_0051);
        chk(disp[7:0] == 8'h51, "R2 alias char", 64'(disp[7:0]), 64'h51);

        // R4 hex word: every nibble value in every position
        for (int p = 0; p < 16; p++) begin
            w = '0;
            for (int i = 0; i < 8; i++) w[31-4*i -: 4] = 4'((p + i) % 16);
            do_wr(32'h0000_0410, w);
            for (int i = 0; i < 8; i++) begin
                chk(disp[8*i +: 8] == hex_asc(4'((p + i) % 16)), "R4 hex char",
                    64'(disp[8*i +: 8]), 64'(hex_asc(4'((p + i) % 16))));
            end
        end

        // R5 single characters over a known hex text
        for (int k = 0; k < 8; k++) begin
            do_wr(32'h0000_0410, 32'h1234_ABCD);
            do_wr(32'h0000_0418 + 32'(8 * k), 32'hFFFF_FF00 | 32'(8'h61 + 8'(k)));
            for (int i = 0; i < 8; i++) begin
                if (i == k) chk(disp[8*i +: 8] == 8'h61 + 8'(k), "R5 char written",
                                64'(disp[8*i +: 8]), 64'(8'h61 + 8'(k)));
                else chk(disp[8*i +: 8] == word_text(32'h1234_ABCD)[8*i +: 8],
                         "R5 char kept", 64'(disp[8*i +: 8]),
                         64'(word_text(32'h1234_ABCD)[8*i +: 8]));
            end
            do_rd(32'h0000_0418 + 32'(8 * k), rd, bad);
            chk(rd == 32'(8'h61 + 8'(k)), "R5 char readback", 64'(rd), 64'(8'h61 + 8'(k)));
        end

        // R7 reset request pulse
        do_wr(32'h0000_0500, 32'h0000_0042);
        chk(rst_req == 1'b1, "R7 pulse high", 64'(rst_req), 64'h1);
        @(negedge clk);
        chk(rst_req == 1'b0, "R7 pulse low", 64'(rst_req), 64'h0);

        // R8 GPO, output-enable, select
        for (int v = 0; v < 256; v += 17) begin
            do_wr(32'h0000_0A00, 32'hFFFF_FF00 | 32'(v));
            chk(gpo == 8'(v), "R8 gpo_o", 64'(gpo), 64'(v));
            do_rd(32'h0000_0A00, rd, bad);
            chk(rd == 32'(v), "R8 gpo readback", 64'(rd), 64'(v));
        end
        for (int v = 0; v < 4; v++) begin
            do_wr(32'h0000_0B00, 32'hFFFF_FFFC | 32'(v));
            chk(i2c_oe == 2'(v), "R8 oe", 64'(i2c_oe), 64'(v));
            do_rd(32'h0000_0B00, rd, bad);
            chk(rd == 32'(v), "R8 oe readback", 64'(rd), 64'(v));
        end
        for (int v = 0; v < 2; v++) begin
            do_wr(32'h0000_0B18, 32'hFFFF_FFFE | 32'(v));
            chk(i2c_sel == 1'(v), "R8 sel", 64'(i2c_sel), 64'(v));
            do_rd(32'h0000_0B18, rd, bad);
            chk(rd == 32'(v), "R8 sel readback", 64'(rd), 64'(v));
        end

        // R9 and R10 I2C lines
        for (int v = 0; v < 4; v++) begin
            do_wr(32'h0000_0B10, 32'hFFFF_FFFC | 32'(v));
            chk({scl, sda} == 2'(v), "R9 scl/sda", 64'({scl, sda}), 64'(v));
            do_rd(32'h0000_0B10, rd, bad);
            chk(rd == 32'(v), "R9 readback", 64'(rd), 64'(v));
            for (int s = 0; s < 2; s++) begin
                sda_in = 1'(s);
                do_rd(32'h0000_0B08, rd, bad);
                chk(rd == 32'({1'(v >> 1), 1'(s)}), "R10 input", 64'(rd),
                    64'({1'(v >> 1), 1'(s)}));
            end
        end
        do_wr(32'h0000_0B08, 32'h0000_0000);
        sda_in = 1'b1;
        do_rd(32'h0000_0B08, rd, bad);
        chk(rd == 32'h3 && {scl, sda} == 2'b11, "R10 write ignored",
            64'({scl, sda, rd}), 64'h3_0000_0003);

        // R11 UART window untouched
        snap_disp = disp; snap_led = led; snap_gpo = gpo;
        snap_io = {i2c_oe, i2c_sel, scl, sda, rst_req};
        do_wr(32'h0000_0900, 32'hFFFF_FFFF);
        do_wr(32'h0000_09F8, 32'hFFFF_FFFF);
        chk(disp == snap_disp && led == snap_led && gpo == snap_gpo &&
            {i2c_oe, i2c_sel, scl, sda, rst_req} == snap_io, "R11 write no effect",
            64'({led, gpo}), 64'({snap_led, snap_gpo}));
        do_rd(32'h0000_0904, rd, bad);
        chk(rd == 32'h0 && !bad, "R11 read quiet", 64'({bad, rd}), 64'h0);

        // R12 unmapped offsets
        begin
            logic [31:0] holes [5] = '{32'h0000_0004, 32'h0000_041C, 32'h0000_0458,
                                       32'h000F_FFFC, 32'h0000_1000};
            for (int h = 0; h < 5; h++) begin
                do_wr(holes[h], 32'hFFFF_FFFF);
                chk(disp == snap_disp && led == snap_led && gpo == snap_gpo,
                    "R12 write no effect", 64'({led, gpo}), 64'({snap_led, snap_gpo}));
                do_rd(holes[h], rd, bad);
                chk(rd == 32'h0 && bad, "R12 bad flag", 64'({bad, rd}), 64'h1_0000_0000);
                @(negedge clk);
                chk(!bus_bad, "R12 flag one cycle", 64'(bus_bad), 64'h0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule